// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

This block is a small bank of independent 32-bit down-counting timers behind a plain synchronous register port. A parameter sets the channel count to two or three. A single shared run register holds one bit per channel, and setting or clearing a bit starts or halts that channel. Each channel has its own reload value, its own live counter and its own control word. The control word picks a prescale ratio, enables the channel's interrupt and holds a sticky underflow flag.

A running channel decrements its counter once for every prescaled tick. A tick that finds the counter at zero reloads it from the reload value and sets the flag. Periodic use loads the same value into both registers. One-shot use loads the counter directly and clears the interrupt enable from the handler. Writing all-ones to both registers gives a free-running count of 2^32 ticks, which can serve as a time base. Software clears the flag by writing the control word with the flag bit at zero. Each channel drives one interrupt line.

The default layout puts the run register at byte offset 0x04 and channel n at 0x08 + 12n. A compact-layout parameter moves these to 0x02 and 0x04 + 12n.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset the run register reads 0, every counter and reload register reads 0xFFFF_FFFF, every control word reads 0 and all interrupt lines are low.
- R2: In the default layout the run register is at 0x04 and holds bits [NUM_CH-1:0], with higher bits always reading 0. Channel n has its reload value at 0x08+12n, its counter at 0x0C+12n and its control word at 0x10+12n. The control word reads back the prescale code in bits [2:0], the interrupt enable in bit 5 and the flag in bit 8, with every other bit reading 0. Reads from any other offset return 0.
- R3: Run bit n starts and halts channel n only, and the other channels are not affected.
- R4: Prescale codes 0, 1, 2, 3 and 4 give one decrement per 4, 16, 64, 256 and 1024 input clocks. With divide ratio D, the first decrement happens on the D-th rising edge after the edge that set the run bit.
- R5: While a channel holds a reserved prescale code (5, 6 or 7), its counter never changes, even when the channel runs.
- R6: A tick that finds the counter at zero loads the reload value into the counter and sets the flag. With a reload value of 0xFFFF_FFFF, the tick after that one gives 0xFFFF_FFFE.
- R7: A halted channel holds its counter. A restarted channel begins a fresh prescale period, so its first decrement takes the full divide ratio.
- R8: A write to a counter or reload register shows up in the next cycle whether or not the channel runs. A counter write on the same edge as a decrement or reload replaces the result of the count.
- R9: A control write with bit 8 at 0 clears the flag. A control write with bit 8 at 1 leaves the flag unchanged.
- R10: If an underflow and a flag-clearing control write fall on the same edge, the flag ends set.
- R11: Interrupt line n is high exactly when channel n's flag and interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe; the write takes effect on the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | NUM_CH | One interrupt line per channel |

## Verification
The hardest case to reach from the ports is an underflow and a software flag clear on the same clock edge. The clear arrives only through the register port, and the underflow only appears after the prescaler has counted a full period. The bench preloads the counter with zero and selects the divide-by-4 ratio. It then issues the clearing write so that its edge is the fourth rising edge after the run write, which is the edge that carries the underflow. The prescaler phase reset on restart is the other timing-sensitive case. The bench halts a channel in mid-period and checks that the first decrement after the restart still needs four full edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Prescale code field and the number of valid divide ratios
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned NUM_CODES = 5;
  // Phase counter wide enough for the largest ratio (1024)
  localparam int unsigned PS_W      = 10;

  // Control word field positions (software decodes these)
  localparam int unsigned CTL_IE_BIT   = 5;
  localparam int unsigned CTL_FLAG_BIT = 8;
  localparam int unsigned CTL_W        = 16;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return c < CODE_W'(NUM_CODES);
  endfunction

  // Last phase value of a prescale period: 4 * 4^code - 1
  function automatic logic [PS_W-1:0] last_phase(input logic [CODE_W-1:0] c);
    logic [PS_W:0] ratio;
    ratio = (PS_W+1)'(4) << {c, 1'b0};
    return PS_W'(ratio - (PS_W+1)'(1));
  endfunction

  function automatic logic [CTL_W-1:0] ctl_word(input logic [CODE_W-1:0] c,
                                                input logic ie,
                                                input logic flag);
    logic [CTL_W-1:0] w;
    w = '0;
    w[CODE_W-1:0]  = c;
    w[CTL_IE_BIT]  = ie;
    w[CTL_FLAG_BIT] = flag;
    return w;
  endfunction

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  logic [PS_W-1:0] phase_q;
  logic [PS_W-1:0] phase_d;
  logic            phase_en;
  logic            at_end;
  logic            ratio_ok;

  always_comb begin
    ratio_ok = code_ok(code);
    at_end   = phase_q >= last_phase(code);
    tick     = run && ratio_ok && at_end;
    // Clock enable: advance while running, or flush a stale phase once halted
    phase_en = run || (phase_q != '0);
    if (!run || !ratio_ok || at_end) phase_d = '0;
    else                             phase_d = phase_q + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              we_rld,
  input  logic              we_cnt,
  input  logic              we_ctl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rld_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic [CODE_W-1:0] code_q,
  output logic              ie_q,
  output logic              flag_q,
  output logic              tick,
  output logic              irq
);

  logic [DATA_W-1:0] cnt_d;
  logic              cnt_en;
  logic              uflow;
  logic              flag_d;
  logic              flag_en;

  tmr_prescaler u_ps (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .code (code_q),
    .tick (tick)
  );

  always_comb begin
    uflow  = tick && (cnt_q == '0);
    cnt_en = we_cnt || tick;
    if (we_cnt)     cnt_d = wdata;
    else if (uflow) cnt_d = rld_q;
    else            cnt_d = cnt_q - DATA_W'(1);
    // Hardware set wins over a same-cycle software clear
    flag_en = uflow || we_ctl;
    flag_d  = uflow || (flag_q && wdata[CTL_FLAG_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rld_q <= '1;
    else if (we_rld) rld_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '1;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ie_q   <= 1'b0;
    end else if (we_ctl) begin
      code_q <= wdata[CODE_W-1:0];
      ie_q   <= wdata[CTL_IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign irq = flag_q && ie_q;

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH  = 3,
  parameter int unsigned COMPACT = 0,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int unsigned RUN_OFS   = (COMPACT != 0) ? 2 : 4;
  localparam int unsigned CH_BASE   = (COMPACT != 0) ? 4 : 8;
  localparam int unsigned CH_STRIDE = 12;
  localparam int unsigned OFS_RLD   = 0;
  localparam int unsigned OFS_CNT   = 4;
  localparam int unsigned OFS_CTL   = 8;

  if (NUM_CH < 2 || NUM_CH > 3) begin : g_bad_ch
    $error("tick_timer_bank: NUM_CH must be 2 or 3");
  end

  logic rst_sync_n;

  tmr_rst_sync u_rst (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(rst_sync_n)
  );

  // Shared run register
  logic [NUM_CH-1:0] run_q;
  logic              we_run;
  logic              hit_run;

  assign hit_run = bus_addr == ADDR_W'(RUN_OFS);
  assign we_run  = bus_we && hit_run;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  run_q <= '0;
    else if (we_run)  run_q <= bus_wdata[NUM_CH-1:0];
  end

  // Per-channel decode and state
  logic [NUM_CH-1:0]             hit_rld, hit_cnt, hit_ctl;
  logic [NUM_CH-1:0]             we_rld_v, we_cnt_v, we_ctl_v;
  logic [NUM_CH-1:0][DATA_W-1:0] rld_v, cnt_v;
  logic [NUM_CH-1:0][CODE_W-1:0] code_v;
  logic [NUM_CH-1:0]             ie_v, flag_v, tick_v;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign hit_rld[g]  = bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*g + OFS_RLD);
    assign hit_cnt[g]  = bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*g + OFS_CNT);
    assign hit_ctl[g]  = bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*g + OFS_CTL);
    assign we_rld_v[g] = bus_we && hit_rld[g];
    assign we_cnt_v[g] = bus_we && hit_cnt[g];
    assign we_ctl_v[g] = bus_we && hit_ctl[g];

    tmr_channel #(.DATA_W(DATA_W)) u_ch (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .run   (run_q[g]),
      .we_rld(we_rld_v[g]),
      .we_cnt(we_cnt_v[g]),
      .we_ctl(we_ctl_v[g]),
      .wdata (bus_wdata),
      .rld_q (rld_v[g]),
      .cnt_q (cnt_v[g]),
      .code_q(code_v[g]),
      .ie_q  (ie_v[g]),
      .flag_q(flag_v[g]),
      .tick  (tick_v[g]),
      .irq   (irq[g])
    );
  end

  // Read mux; unmapped offsets return zero
  always_comb begin
    bus_rdata = '0;
    if (hit_run) bus_rdata[NUM_CH-1:0] = run_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit_rld[i]) bus_rdata = rld_v[i];
      if (hit_cnt[i]) bus_rdata = cnt_v[i];
      if (hit_ctl[i]) bus_rdata = DATA_W'(ctl_word(code_v[i], ie_v[i], flag_v[i]));
    end
  end

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned DATA_W = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            run,
  input logic [NUM_CH-1:0]            we_cnt,
  input logic [NUM_CH-1:0]            we_ctl,
  input logic                         keep_bit,
  input logic [NUM_CH-1:0][DATA_W-1:0] cnt,
  input logic [NUM_CH-1:0][DATA_W-1:0] rld,
  input logic [NUM_CH-1:0]            flag,
  input logic [NUM_CH-1:0]            tick
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !we_cnt[i]) |=> cnt[i] == $past(cnt[i]));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[i] && cnt[i] != '0 && !we_cnt[i]) |=> cnt[i] == $past(cnt[i]) - DATA_W'(1));

    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[i] && cnt[i] == '0 && !we_cnt[i]) |=> (cnt[i] == $past(rld[i])) && flag[i]);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[i] && cnt[i] == '0) |=> flag[i]);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_ctl[i] && !keep_bit && !(tick[i] && cnt[i] == '0)) |=> !flag[i]);

    // R3
    tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick[i] |-> run[i]);
  end

endmodule

bind tick_timer_bank tmr_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .run     (run_q),
  .we_cnt  (we_cnt_v),
  .we_ctl  (we_ctl_v),
  .keep_bit(bus_wdata[8]),
  .cnt     (cnt_v),
  .rld     (rld_v),
  .flag    (flag_v),
  .tick    (tick_v)
);

// File: tb/tick_timer_bank_bench.sv
module tick_timer_bank_bench;

  localparam int NCH = 3;
  localparam logic [7:0] A_RUN = 8'h04;

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  tick_timer_bank u_tick_timer_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] a_rld(int n); return 8'(8 + 12*n); endfunction
  function automatic logic [7:0] a_cnt(int n); return 8'(12 + 12*n); endfunction
  function automatic logic [7:0] a_ctl(int n); return 8'(16 + 12*n); endfunction

  // Called at a negedge; the write lands on the following rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic expect_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic expect_irq(input string tag, input logic [NCH-1:0] exp);
    check(tag, 32'(irq), 32'(exp));
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic print_summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic t_reset;
    expect_rd("R1 run", A_RUN, 32'h0);
    for (int n = 0; n < NCH; n++) begin
      expect_rd("R1 reload", a_rld(n), 32'hFFFF_FFFF);
      expect_rd("R1 counter", a_cnt(n), 32'hFFFF_FFFF);
      expect_rd("R1 control", a_ctl(n), 32'h0);
    end
    expect_irq("R1 irq", '0);
  endtask

  task automatic t_map;
    for (int n = 0; n < NCH; n++) begin
      wr(a_rld(n), 32'h1000_0000 + 32'(n));
      wr(a_cnt(n), 32'h2000_0000 + 32'(n));
    end
    for (int n = 0; n < NCH; n++) begin
      expect_rd("R2 reload", a_rld(n), 32'h1000_0000 + 32'(n));
      expect_rd("R2 counter", a_cnt(n), 32'h2000_0000 + 32'(n));
    end
    wr(a_ctl(1), 32'h0000_FEDF);
    expect_rd("R2 control bits", a_ctl(1), 32'h0000_0007);
    wr(a_ctl(1), 32'h0000_0000);
    wr(A_RUN, 32'hFFFF_FFF8);
    expect_rd("R2 run upper bits", A_RUN, 32'h0);
    expect_rd("R2 unmapped 00", 8'h00, 32'h0);
    expect_rd("R2 unmapped 06", 8'h06, 32'h0);
    expect_rd("R2 unmapped 2C", 8'h2C, 32'h0);
  endtask

  task automatic t_count_div4;
    wr(a_ctl(0), 32'h0);
    wr(a_rld(0), 32'd5);
    wr(a_cnt(0), 32'd3);
    wr(A_RUN, 32'h1);
    wait_n(3);
    expect_rd("R4 before first tick", a_cnt(0), 32'd3);
    wait_n(1);
    expect_rd("R4 first tick", a_cnt(0), 32'd2);
    wait_n(8);
    expect_rd("R4 third tick", a_cnt(0), 32'd0);
    wait_n(4);
    expect_rd("R6 reload", a_cnt(0), 32'd5);
    expect_rd("R6 flag set", a_ctl(0), 32'h0000_0100);
    expect_irq("R11 masked", '0);
    wr(A_RUN, 32'h0);
    wr(a_ctl(0), 32'h0);
  endtask

  task automatic t_prescale;
    wr(a_ctl(1), 32'd1);
    wr(a_cnt(1), 32'd100);
    wr(a_ctl(2), 32'd4);
    wr(a_cnt(2), 32'd50);
    wr(A_RUN, 32'h6);
    wait_n(15);
    expect_rd("R4 div16 edge15", a_cnt(1), 32'd100);
    wait_n(1);
    expect_rd("R4 div16 edge16", a_cnt(1), 32'd99);
    wait_n(1007);
    expect_rd("R4 div1024 edge1023", a_cnt(2), 32'd50);
    expect_rd("R4 div16 edge1023", a_cnt(1), 32'd37);
    wait_n(1);
    expect_rd("R4 div1024 edge1024", a_cnt(2), 32'd49);
    expect_rd("R3 halted channel untouched", a_cnt(0), 32'd5);
    wr(A_RUN, 32'h0);
  endtask

  task automatic t_reserved;
    wr(a_ctl(1), 32'd5);
    wr(a_cnt(1), 32'd20);
    wr(A_RUN, 32'h2);
    wait_n(200);
    expect_rd("R5 code 5", a_cnt(1), 32'd20);
    wr(a_ctl(1), 32'd7);
    wait_n(200);
    expect_rd("R5 code 7", a_cnt(1), 32'd20);
    wr(A_RUN, 32'h0);
  endtask

  task automatic t_halt;
    wr(a_ctl(0), 32'h0);
    wr(a_cnt(0), 32'd10);
    wr(A_RUN, 32'h1);
    wait_n(6);
    wr(A_RUN, 32'h0);
    wait_n(20);
    expect_rd("R7 hold", a_cnt(0), 32'd9);
    wr(A_RUN, 32'h1);
    wait_n(3);
    expect_rd("R7 fresh phase", a_cnt(0), 32'd9);
    wait_n(1);
    expect_rd("R7 first tick after restart", a_cnt(0), 32'd8);
    wr(A_RUN, 32'h0);
  endtask

  task automatic t_write_running;
    wr(a_cnt(0), 32'd40);
    wr(A_RUN, 32'h1);
    wait_n(3);
    wr(a_cnt(0), 32'd77);
    expect_rd("R8 write beats tick", a_cnt(0), 32'd77);
    wr(a_rld(0), 32'd9);
    expect_rd("R8 reload while running", a_rld(0), 32'd9);
    wait_n(2);
    expect_rd("R8 before next tick", a_cnt(0), 32'd77);
    wait_n(1);
    expect_rd("R8 counting resumes", a_cnt(0), 32'd76);
    wr(A_RUN, 32'h0);
  endtask

  task automatic t_flag;
    wr(a_rld(0), 32'd2);
    wr(a_cnt(0), 32'd0);
    wr(a_ctl(0), 32'h20);
    wr(A_RUN, 32'h1);
    wait_n(3);
    expect_irq("R11 before underflow", 3'b000);
    wait_n(1);
    expect_irq("R11 after underflow", 3'b001);
    expect_rd("R6 flag and enable", a_ctl(0), 32'h0000_0120);
    wr(A_RUN, 32'h0);
    wr(a_ctl(0), 32'h0000_0120);
    expect_rd("R9 keep flag", a_ctl(0), 32'h0000_0120);
    expect_irq("R9 irq kept", 3'b001);
    wr(a_ctl(0), 32'h0000_0020);
    expect_rd("R9 clear flag", a_ctl(0), 32'h0000_0020);
    expect_irq("R11 cleared", 3'b000);
  endtask

  task automatic t_collide;
    wr(a_rld(0), 32'd7);
    wr(a_cnt(0), 32'd0);
    wr(a_ctl(0), 32'h20);
    wr(A_RUN, 32'h1);
    wait_n(3);
    wr(a_ctl(0), 32'h0000_0020);
    expect_rd("R10 set wins", a_ctl(0), 32'h0000_0120);
    expect_rd("R10 reload", a_cnt(0), 32'd7);
    expect_irq("R10 irq", 3'b001);
    wr(A_RUN, 32'h0);
    wr(a_ctl(0), 32'h0);
    expect_rd("R9 clear after collision", a_ctl(0), 32'h0);
  endtask

  task automatic t_longest;
    wr(a_ctl(2), 32'h0);
    wr(a_rld(2), 32'hFFFF_FFFF);
    wr(a_cnt(2), 32'd0);
    wr(A_RUN, 32'h4);
    wait_n(4);
    expect_rd("R6 all-ones reload", a_cnt(2), 32'hFFFF_FFFF);
    wait_n(4);
    expect_rd("R6 all-ones continues", a_cnt(2), 32'hFFFF_FFFE);
    wr(A_RUN, 32'h0);
    wr(a_ctl(2), 32'h0);
  endtask

  initial begin
    rst_n     = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_map();
    t_count_div4();
    t_prescale();
    t_reserved();
    t_halt();
    t_write_running();
    t_flag();
    t_collide();
    t_longest();
    done = 1;
    print_summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: all requirements, got timeout expected completion");
      print_summary();
      $finish;
    end
  end

endmodule